// File: doc/BRIEF.md
# Self-Triggered Segmented Sample Buffer

This block sits behind a fast sample stream and keeps only the short stretches of it that matter. Whenever the trigger input is raised, the writer claims the next free segment and starts storing the incoming samples in that same cycle, together with the timestamp present at the trigger. No handshake with the reader is needed. A segment is a fixed run of 32 samples. The storage ring holds 128 segments (4096 sample cells), so bursts of hits are absorbed and later drained at the pace of the readout.

The read side sees completed segments in the order they were captured. It steps through the current segment one sample per read enable. It flags the first sample, which also carries the trigger timestamp, and the last one. The reader may also drop the current segment at any point with a skip strobe, which acts as a reject from a later trigger stage. Writing and reading run at the same time. As long as the average hit rate stays below one segment per readout time, no hit is lost. When the ring is full, triggers are counted as lost events instead of being stored.

Top module: `trig_seg_buffer`

## Requirements
- R1: While reset is held and right after it, `seg_valid_o` is 0, `used_o` is 0, `lost_cnt_o` is 0 and `rd_first_o` is 1.
- R2: The writer accepts a trigger when it is idle and `used_o` is below 128. The sample presented in the trigger cycle becomes sample index 0, with `ts_i` of that cycle as the timestamp. The samples of the next 31 cycles become indices 1 to 31. `used_o` rises by one at the clock edge that stores index 31, which is the 31st edge after the trigger edge.
- R3: A trigger that arrives while a segment is still being filled, including the cycle of its last sample, creates no segment and does not change the data being written. A trigger in the cycle right after the last sample is accepted.
- R4: A trigger that arrives while the writer is idle and `used_o` equals 128 is dropped, and `lost_cnt_o` rises by one. The counter saturates at 255. Accepted triggers and ignored triggers never change it.
- R5: Segments are delivered to the read port strictly in the order their triggers were accepted. This includes the case where the ring pointers wrap.
- R6: While `seg_valid_o` is 1, `rd_data_o` shows the current sample of the oldest segment. Each cycle with `rd_en_i` high moves to the next index. `rd_first_o` is high at index 0, where `rd_ts_o` equals that segment's trigger timestamp. `rd_last_o` is high at index 31. A read enable at index 31 frees the segment.
- R7: With `seg_valid_o` high, `skip_i` frees the oldest segment at the next edge, even when it is partly read. It takes priority over `rd_en_i`, and the next segment starts at index 0.
- R8: With no stored segment, `rd_en_i` and `skip_i` have no effect: `used_o` stays 0, the read index stays at 0, and the next captured segment reads back correctly.
- R9: Capture and readout proceed in the same cycles. A segment that completes in the same cycle as another segment is freed leaves `used_o` unchanged.
- R10: `used_o` equals the number of completed, unfreed segments and never exceeds 128. `seg_valid_o` is 1 exactly when `used_o` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 12 | Sample stream, one sample per cycle |
| ts_i | input | 16 | Timestamp captured with a trigger |
| trig_i | input | 1 | Hit trigger |
| rd_en_i | input | 1 | Advance the read index by one sample |
| skip_i | input | 1 | Discard the oldest stored segment |
| seg_valid_o | output | 1 | At least one completed segment is stored |
| rd_data_o | output | 12 | Current read sample |
| rd_ts_o | output | 16 | Trigger timestamp of the oldest segment |
| rd_first_o | output | 1 | Read index is 0 |
| rd_last_o | output | 1 | Read index is 31 |
| used_o | output | 8 | Number of completed stored segments |
| lost_cnt_o | output | 8 | Saturating count of triggers dropped on a full ring |

## Verification
The hardest condition to reach from the ports is a full ring, and beyond it a saturated lost counter. This takes 128 completed segments, so the stimulus fires 128 triggers spaced exactly 32 cycles apart, each at the earliest cycle the writer accepts. It then holds the trigger high for more than 255 cycles, so that both the saturation and the oldest-first order after the head pointer wraps can be checked. Triggers aimed at the first and last sample cycles of a capture check the edges of the busy window. A trigger raised in the middle of a readout checks that capture and readout overlap correctly.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_FILL = 1'b1
  } wr_state_e;
endpackage

// File: rtl/seg_wr_ctrl.sv
module seg_wr_ctrl
  import segbuf_pkg::*;
#(
  parameter int NUM_SEG = 128,
  parameter int SEG_LEN = 32,
  parameter int LOST_W  = 8,
  localparam int PTR_W = $clog2(NUM_SEG),
  localparam int IDX_W = $clog2(SEG_LEN),
  localparam int CNT_W = $clog2(NUM_SEG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [CNT_W-1:0]  used_i,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_seg_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              ts_we_o,
  output logic              commit_o,
  output logic [LOST_W-1:0] lost_cnt_o
);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(NUM_SEG);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(SEG_LEN - 1);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  wr_state_e         state_q;
  logic [PTR_W-1:0]  head_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LOST_W-1:0] lost_q;
  logic              idle, accept, drop;

  assign idle   = (state_q == WR_IDLE);
  assign accept = idle && trig_i && (used_i != FULL_CNT);
  assign drop   = idle && trig_i && (used_i == FULL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      head_q  <= '0;
      idx_q   <= '0;
    end else if (accept) begin
      state_q <= WR_FILL;
      idx_q   <= IDX_W'(1);
    end else if (!idle) begin
      if (idx_q == LAST_IDX) begin
        state_q <= WR_IDLE;
        idx_q   <= '0;
        head_q  <= head_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lost_q <= '0;
    else if (drop && (lost_q != LOST_MAX)) lost_q <= lost_q + 1'b1;
  end

  assign wr_en_o    = accept || !idle;
  assign wr_seg_o   = head_q;
  assign wr_idx_o   = idle ? '0 : idx_q;
  assign ts_we_o    = accept;
  assign commit_o   = !idle && (idx_q == LAST_IDX);
  assign lost_cnt_o = lost_q;
endmodule

// File: rtl/seg_rd_ctrl.sv
module seg_rd_ctrl #(
  parameter int NUM_SEG = 128,
  parameter int SEG_LEN = 32,
  localparam int PTR_W = $clog2(NUM_SEG),
  localparam int IDX_W = $clog2(SEG_LEN),
  localparam int CNT_W = $clog2(NUM_SEG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] used_i,
  output logic [PTR_W-1:0] rd_seg_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             valid_o,
  output logic             first_o,
  output logic             last_o,
  output logic             free_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEG_LEN - 1);

  logic [PTR_W-1:0] tail_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid;

  assign valid  = (used_i != '0);
  // skip wins over a plain read
  assign free_o = valid && (skip_i || (rd_en_i && (idx_q == LAST_IDX)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
      idx_q  <= '0;
    end else if (free_o) begin
      tail_q <= tail_q + 1'b1;
      idx_q  <= '0;
    end else if (valid && rd_en_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign rd_seg_o = tail_q;
  assign rd_idx_o = idx_q;
  assign valid_o  = valid;
  assign first_o  = (idx_q == '0);
  assign last_o   = (idx_q == LAST_IDX);
endmodule

// File: rtl/seg_occ.sv
module seg_occ #(
  parameter int NUM_SEG = 128,
  localparam int CNT_W = $clog2(NUM_SEG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             free_i,
  output logic [CNT_W-1:0] used_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (commit_i && !free_i) cnt_q <= cnt_q + 1'b1;
    else if (free_i && !commit_i) cnt_q <= cnt_q - 1'b1;
  end

  assign used_o = cnt_q;
endmodule

// File: rtl/seg_store.sv
module seg_store #(
  parameter int NUM_SEG = 128,
  parameter int SEG_LEN = 32,
  parameter int DATA_W  = 12,
  parameter int TS_W    = 16,
  localparam int PTR_W = $clog2(NUM_SEG),
  localparam int IDX_W = $clog2(SEG_LEN),
  localparam int CELLS = NUM_SEG * SEG_LEN
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_seg_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ts_we_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [PTR_W-1:0]  rd_seg_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TS_W-1:0]   rd_ts_o
);
  logic [DATA_W-1:0] cell_q [CELLS];
  logic [TS_W-1:0]   stamp_q [NUM_SEG];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) cell_q[{wr_seg_i, wr_idx_i}] <= wr_data_i;
    if (ts_we_i) stamp_q[wr_seg_i] <= ts_i;
  end

  assign rd_data_o = cell_q[{rd_seg_i, rd_idx_i}];
  assign rd_ts_o   = stamp_q[rd_seg_i];
endmodule

// File: rtl/trig_seg_buffer.sv
module trig_seg_buffer #(
  parameter int NUM_SEG = 128,
  parameter int SEG_LEN = 32,
  parameter int DATA_W  = 12,
  parameter int TS_W    = 16,
  parameter int LOST_W  = 8,
  localparam int CNT_W = $clog2(NUM_SEG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              trig_i,
  input  logic              rd_en_i,
  input  logic              skip_i,
  output logic              seg_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TS_W-1:0]   rd_ts_o,
  output logic              rd_first_o,
  output logic              rd_last_o,
  output logic [CNT_W-1:0]  used_o,
  output logic [LOST_W-1:0] lost_cnt_o
);
  // ring pointers wrap by overflow: NUM_SEG and SEG_LEN must be powers of two
  localparam int PTR_W = $clog2(NUM_SEG);
  localparam int IDX_W = $clog2(SEG_LEN);

  logic             wr_en, ts_we, commit, free;
  logic [PTR_W-1:0] wr_seg, rd_seg;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [CNT_W-1:0] used;

  seg_wr_ctrl #(.NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .LOST_W(LOST_W)) u_wr (
    .clk_i, .rst_ni, .trig_i, .used_i(used),
    .wr_en_o(wr_en), .wr_seg_o(wr_seg), .wr_idx_o(wr_idx),
    .ts_we_o(ts_we), .commit_o(commit), .lost_cnt_o(lost_cnt_o)
  );

  seg_rd_ctrl #(.NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN)) u_rd (
    .clk_i, .rst_ni, .rd_en_i, .skip_i, .used_i(used),
    .rd_seg_o(rd_seg), .rd_idx_o(rd_idx), .valid_o(seg_valid_o),
    .first_o(rd_first_o), .last_o(rd_last_o), .free_o(free)
  );

  seg_occ #(.NUM_SEG(NUM_SEG)) u_occ (
    .clk_i, .rst_ni, .commit_i(commit), .free_i(free), .used_o(used)
  );

  seg_store #(.NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .DATA_W(DATA_W), .TS_W(TS_W)) u_mem (
    .clk_i, .wr_en_i(wr_en), .wr_seg_i(wr_seg), .wr_idx_i(wr_idx), .wr_data_i(smp_i),
    .ts_we_i(ts_we), .ts_i, .rd_seg_i(rd_seg), .rd_idx_i(rd_idx),
    .rd_data_o, .rd_ts_o
  );

  assign used_o = used;
endmodule

// File: rtl/trig_seg_buffer_chk.sv
module trig_seg_buffer_chk #(
  parameter int NUM_SEG = 128,
  parameter int LOST_W  = 8,
  localparam int CNT_W = $clog2(NUM_SEG + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_i,
  input logic              rd_en_i,
  input logic              skip_i,
  input logic              seg_valid_o,
  input logic              rd_first_o,
  input logic              rd_last_o,
  input logic [CNT_W-1:0]  used_o,
  input logic [LOST_W-1:0] lost_cnt_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SEG);

  AST_USED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= FULL_CNT); // R10
  AST_USED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_o == $past(used_o)) || (used_o == $past(used_o) + 1'b1) ||
    (used_o == $past(used_o) - 1'b1)); // R9
  AST_LOST_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_cnt_o >= $past(lost_cnt_o)); // R4
  AST_LOST_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && (used_o != FULL_CNT)) |=> $stable(lost_cnt_o)); // R4
  AST_EMPTY_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seg_valid_o && (rd_en_i || skip_i)) |=> rd_first_o); // R8
  AST_SKIP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i && seg_valid_o) |=> rd_first_o); // R7
  AST_READ_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && rd_en_i && !skip_i && !rd_last_o) |=> !rd_first_o); // R6
  AST_FIRST_NOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_first_o && rd_last_o)); // R6
endmodule

bind trig_seg_buffer trig_seg_buffer_chk #(.NUM_SEG(NUM_SEG), .LOST_W(LOST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .rd_en_i(rd_en_i), .skip_i(skip_i),
  .seg_valid_o(seg_valid_o), .rd_first_o(rd_first_o), .rd_last_o(rd_last_o),
  .used_o(used_o), .lost_cnt_o(lost_cnt_o)
);

// File: tb/sim_trig_seg_buffer.sv
module sim_trig_seg_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] smp = '0;
  logic [15:0] ts = '0;
  logic        trig = 1'b0, rd_en = 1'b0, skip = 1'b0;
  logic        seg_valid, rd_first, rd_last;
  logic [11:0] rd_data;
  logic [15:0] rd_ts;
  logic [7:0]  used, lost;

  trig_seg_buffer u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .ts_i(ts), .trig_i(trig),
    .rd_en_i(rd_en), .skip_i(skip), .seg_valid_o(seg_valid), .rd_data_o(rd_data),
    .rd_ts_o(rd_ts), .rd_first_o(rd_first), .rd_last_o(rd_last),
    .used_o(used), .lost_cnt_o(lost)
  );

  always #4 clk = ~clk;

  // gap to next trigger [15:8], offset of an extra trigger [7:0] (0 = none)
  localparam logic [15:0] VEC [6] = '{16'h2000, 16'h2805, 16'h201F, 16'h2101, 16'h3200, 16'h2010};

  int cyc = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  int q[$];
  bit pend = 0;
  int pend_c = 0;
  int ridx = 0;
  int m_lost = 0;

  function automatic logic [11:0] pat(input int c);
    return 12'((c * 37) ^ (c >> 2));
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    smp <= pat(cyc);
    ts  <= 16'(cyc);
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void sync_model();
    if (pend && (cyc >= pend_c + 32)) begin
      q.push_back(pend_c);
      pend = 0;
    end
  endfunction

  function automatic void model_trig();
    if (pend) return;
    if (q.size() >= 128) begin
      if (m_lost < 255) m_lost++;
    end else begin
      pend = 1;
      pend_c = cyc;
    end
  endfunction

  function automatic void model_rd();
    if (q.size() > 0) begin
      ridx++;
      if (ridx == 32) begin
        void'(q.pop_front());
        ridx = 0;
      end
    end
  endfunction

  function automatic void model_skip();
    if (q.size() > 0) begin
      void'(q.pop_front());
      ridx = 0;
    end
  endfunction

  task automatic step();
    @(negedge clk);
    sync_model();
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic fire();
    trig = 1'b1;
    model_trig();
    step();
    trig = 1'b0;
  endtask

  task automatic skip_one();
    skip = 1'b1;
    model_skip();
    step();
    skip = 1'b0;
  endtask

  task automatic chk_counts(input string tag);
    chk_eq({tag, " used"}, int'(used), q.size());
    chk_eq({tag, " lost"}, int'(lost), m_lost);
  endtask

  task automatic chk_front(input string tag);
    if (q.size() == 0) begin
      chk_eq({tag, " valid low"}, int'(seg_valid), 0);
    end else begin
      chk_eq({tag, " valid"}, int'(seg_valid), 1);
      chk_eq({tag, " R6 data"}, int'(rd_data), int'(pat(q[0] + ridx)));
      chk_eq({tag, " R6 first"}, int'(rd_first), int'(ridx == 0));
      chk_eq({tag, " R6 last"}, int'(rd_last), int'(ridx == 31));
      if (ridx == 0) chk_eq({tag, " R6 ts"}, int'(rd_ts), q[0] & 16'hFFFF);
    end
  endtask

  task automatic read_n(input string tag, input int n, input int fire_at);
    for (int i = 0; i < n; i++) begin
      chk_front(tag);
      if (i == fire_at) begin
        trig = 1'b1;
        model_trig();
      end
      rd_en = 1'b1;
      model_rd();
      step();
      rd_en = 1'b0;
      trig = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int u0v;
    int c0;
    repeat (3) @(negedge clk);
    chk_eq("R1 valid in reset", int'(seg_valid), 0);
    chk_eq("R1 used in reset", int'(used), 0);
    rst_n = 1'b1;
    step();
    chk_eq("R1 valid after reset", int'(seg_valid), 0);
    chk_eq("R1 used after reset", int'(used), 0);
    chk_eq("R1 lost after reset", int'(lost), 0);
    chk_eq("R1 first after reset", int'(rd_first), 1);

    // R2: completion edge
    u0v = int'(used);
    c0 = cyc;
    fire();
    idle(c0 + 31 - cyc);
    chk_eq("R2 used before last sample edge", int'(used), u0v);
    step();
    chk_eq("R2 used after last sample edge", int'(used), u0v + 1);

    // R3: table of trigger gaps and extra triggers inside the busy window
    for (int v = 0; v < 6; v++) begin
      int c, g, e;
      g = int'(VEC[v][15:8]);
      e = int'(VEC[v][7:0]);
      c = cyc;
      fire();
      if (e != 0) begin
        idle(e - 1);
        fire();
      end
      idle(c + g - cyc);
    end
    idle(32);
    chk_eq("R3 segments after extra triggers", int'(used), 7);
    chk_counts("R3 model");

    // R5/R9: read two segments in order, with a capture during the first
    read_n("R9 read during capture", 32, 3);
    read_n("R5 second segment", 32, -1);
    idle(40);
    chk_counts("R9 overlap");

    // R7: skip a partly read segment, then an unread one
    read_n("R7 partial", 5, -1);
    skip_one();
    chk_front("R7 after partial skip");
    skip_one();
    chk_front("R7 after whole skip");
    chk_counts("R7 counts");

    // drain
    while (q.size() > 0) read_n("R5 drain", 32 - ridx, -1);
    chk_counts("R5 drained");

    // R8: read and skip on empty
    rd_en = 1'b1;
    skip = 1'b1;
    idle(3);
    rd_en = 1'b0;
    skip = 1'b0;
    chk_eq("R8 used stays 0", int'(used), 0);
    chk_eq("R8 valid stays 0", int'(seg_valid), 0);
    chk_eq("R8 read index stays 0", int'(rd_first), 1);
    fire();
    idle(40);
    read_n("R8 capture after empty ops", 32, -1);

    // R10/R4: fill the ring, saturate the lost counter
    for (int k = 0; k < 128; k++) begin
      fire();
      idle(31);
    end
    chk_eq("R10 full ring", int'(used), 128);
    chk_eq("R10 valid when full", int'(seg_valid), 1);
    chk_eq("R4 nothing lost yet", int'(lost), 0);
    repeat (10) fire();
    chk_eq("R4 ten dropped", int'(lost), 10);
    repeat (260) fire();
    chk_eq("R4 lost saturates", int'(lost), 255);
    chk_eq("R4 used still full", int'(used), 128);
    read_n("R5 oldest after wrap", 32, -1);
    fire();
    idle(31);
    chk_eq("R4 refill accepted", int'(used), 128);
    chk_eq("R4 lost unchanged by accept", int'(lost), 255);
    chk_counts("R4 model");

    repeat (128) skip_one();
    chk_eq("R7 skip all", int'(used), 0);
    chk_eq("R7 empty after skips", int'(seg_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule